// File: doc/BRIEF.md
# Transmit Packet Framer with Payload Buffer

The block turns one packet into a serial bit stream and sends one bit for each symbol-enable tick. A packet is made of five fields in a fixed order: a preamble, a sync word, a trailer, the payload and an optional 16-bit CRC. The host configures each field through static configuration inputs. Before a packet, the host loads the payload bytes into a 64-byte buffer through a byte-write port. It then pulses a start strobe. The block runs each field in turn, pulls payload bytes from the buffer as it needs them, and computes the CRC over the payload while it is sent.

The buffer read pointer goes back to the start of the buffer as soon as the last sync bit leaves. A payload longer than the buffer is allowed, provided the host keeps writing while the packet is on air. If the buffer runs dry in the middle of the payload, the block sends zero bytes in place of the missing ones and raises a sticky underflow flag.

Top module: `pkt_framer_tx`

## Requirements
- R1: After reset the block is idle: txStrobe, pktBusy, pktDone and underflow are 0, and fifoEmpty is 1.
- R2: The preamble is (cfgPreLen+1) bytes of 0xAA, sent MSB first, so the bits run 1,0,1,0 and so on. Each bit appears on txBit with txStrobe high in the cycle after a clock edge at which symTick was high.
- R3: The sync word follows the preamble. It is 32 bits wide when cfgSyncSel is 0, 48 bits when it is 1, and 64 bits when it is 2 or 3. It is sent from bit (width-1) of cfgSyncWord down to bit 0.
- R4: The trailer follows the sync word and is cfgTrailLen bits long. Values below 4 are raised to 4 and values above 16 are cut to 16. Its bits alternate 1,0,1,0, starting with 1.
- R5: The payload follows the trailer. It is cfgPayLen bytes, each sent MSB first, taken from the buffer in the order they were written. The read position returns to buffer slot 0 when the last sync bit is sent.
- R6: When cfgCrcEn is 1, 16 CRC bits follow the payload, MSB first. The CRC uses the polynomial 0x1021, starts from 0xFFFF, has no final inversion, and covers the payload bits only. When cfgCrcEn is 0, no CRC is sent.
- R7: The buffer holds 64 bytes. fifoEmpty is 1 when it holds none and fifoFull is 1 when it holds 64. A write while the buffer is full is dropped.
- R8: A cycle with clrBuf high empties the buffer, setting both the write position and the read position to slot 0. clrBuf wins over a write in the same cycle.
- R9: A payload byte needed while the buffer is empty is sent as 0x00 and sets underflow. Underflow stays set until the next accepted start.
- R10: pktBusy is high from the edge that accepts startPulse until the last bit of the packet. pktDone pulses for one cycle together with the strobe of that last bit. A start while busy is ignored.
- R11: A payload longer than 64 bytes is sent without underflow when the host refills the buffer during the packet.
- R12: With cfgPayLen equal to 0, the trailer is followed directly by the CRC, or ends the packet when the CRC is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symTick | input | 1 | Symbol enable: one bit goes out per tick |
| startPulse | input | 1 | Starts a packet when the block is idle |
| cfgPreLen | input | 3 | Preamble length in bytes, minus one |
| cfgSyncSel | input | 2 | Sync width select: 32, 48 or 64 bits |
| cfgSyncWord | input | 64 | Sync word value, right-aligned |
| cfgTrailLen | input | 5 | Trailer length in bits, clamped to 4..16 |
| cfgCrcEn | input | 1 | Appends the 16-bit CRC |
| cfgPayLen | input | PAYW | Payload length in bytes |
| wrEn | input | 1 | Buffer byte write enable |
| wrData | input | 8 | Buffer write byte |
| clrBuf | input | 1 | Empties the buffer |
| txBit | output | 1 | Serial output bit |
| txStrobe | output | 1 | Marks a valid txBit |
| pktBusy | output | 1 | A packet is in progress |
| pktDone | output | 1 | One-cycle pulse with the last bit |
| underflow | output | 1 | Sticky flag: a payload byte was substituted |
| fifoEmpty | output | 1 | Buffer empty |
| fifoFull | output | 1 | Buffer full |

## Verification
The checker takes the configuration inputs as stable for the whole of a packet. It also assumes that clrBuf is never raised while a packet is on air, so the only things that move the buffer pointers during a packet are payload fetches, host writes and the return to slot 0 after the sync word. The bench changes configuration only while pktBusy is low and clears the buffer only between packets. It spaces the symbol ticks three cycles apart, so that every refill write in the long-packet case lands well before the byte it supplies is fetched.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic [2:0] {
    FLD_IDLE,
    FLD_PRE,
    FLD_SYNC,
    FLD_TRAIL,
    FLD_PAY,
    FLD_CRC
  } fieldT;

  typedef struct packed {
    logic       emit;
    fieldT      field;
    logic [6:0] bitIdx;
    logic       byteFirst;
    logic       crcInit;
    logic       rdRst;
    logic       lastBit;
  } ctrlStrobeT;

  function automatic logic [6:0] syncBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd32;
      2'd1:    return 7'd48;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [6:0] trailBits(input logic [4:0] len);
    if (len < 5'd4)       return 7'd4;
    else if (len > 5'd16) return 7'd16;
    else                  return {2'b00, len};
  endfunction

endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int PAYW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            symTick,
  input  logic [2:0]      cfgPreLen,
  input  logic [1:0]      cfgSyncSel,
  input  logic [4:0]      cfgTrailLen,
  input  logic            cfgCrcEn,
  input  logic [PAYW-1:0] cfgPayLen,
  output ctrlStrobeT      strb,
  output logic            busy
);

  fieldT           state, nextField;
  logic [6:0]      cnt, fieldLen;
  logic [PAYW-1:0] byteCnt;
  logic            lastInField, lastByte, fieldEnd, emit;

  always_comb begin
    case (state)
      FLD_PRE:   fieldLen = 7'(({4'd0, cfgPreLen} + 7'd1) << 3);
      FLD_SYNC:  fieldLen = syncBits(cfgSyncSel);
      FLD_TRAIL: fieldLen = trailBits(cfgTrailLen);
      FLD_PAY:   fieldLen = 7'd8;
      FLD_CRC:   fieldLen = 7'd16;
      default:   fieldLen = 7'd1;
    endcase
  end

  assign lastInField = (cnt == fieldLen - 7'd1);
  assign lastByte    = (byteCnt == cfgPayLen - PAYW'(1));
  assign fieldEnd    = lastInField && (state != FLD_PAY || lastByte);
  assign emit        = symTick && (state != FLD_IDLE);

  always_comb begin
    case (state)
      FLD_PRE:   nextField = FLD_SYNC;
      FLD_SYNC:  nextField = FLD_TRAIL;
      FLD_TRAIL: nextField = (cfgPayLen != '0) ? FLD_PAY : (cfgCrcEn ? FLD_CRC : FLD_IDLE);
      FLD_PAY:   nextField = cfgCrcEn ? FLD_CRC : FLD_IDLE;
      default:   nextField = FLD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= FLD_IDLE;
      cnt     <= '0;
      byteCnt <= '0;
    end else if (state == FLD_IDLE) begin
      if (startPulse) begin
        state   <= FLD_PRE;
        cnt     <= '0;
        byteCnt <= '0;
      end
    end else if (symTick) begin
      if (lastInField) begin
        cnt <= '0;
        if (fieldEnd) begin
          state   <= nextField;
          byteCnt <= '0;
        end else begin
          byteCnt <= byteCnt + PAYW'(1);
        end
      end else begin
        cnt <= cnt + 7'd1;
      end
    end
  end

  assign busy           = (state != FLD_IDLE);
  assign strb.emit      = emit;
  assign strb.field     = state;
  assign strb.bitIdx    = cnt;
  assign strb.byteFirst = (state == FLD_PAY) && (cnt[2:0] == 3'd0);
  assign strb.crcInit   = (state == FLD_IDLE) && startPulse;
  assign strb.rdRst     = emit && (state == FLD_SYNC) && lastInField;
  assign strb.lastBit   = emit && fieldEnd && (nextField == FLD_IDLE);

endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobeT  strb,
  input  logic [1:0]  cfgSyncSel,
  input  logic [63:0] cfgSyncWord,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        clrBuf,
  output logic        txBit,
  output logic        txStrobe,
  output logic        pktDone,
  output logic        underflow,
  output logic        fifoEmpty,
  output logic        fifoFull
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [7:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, fill;
  logic [7:0]  headByte, shReg;
  logic [15:0] crcReg, crcNext;
  logic [6:0]  syncIdx;
  logic        curBit, pop;

  assign fill      = wrPtr - rdPtr;
  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = (fill == PW'(DEPTH));
  assign headByte  = fifoEmpty ? 8'h00 : mem[rdPtr[AW-1:0]];
  assign pop       = strb.emit && strb.byteFirst && !fifoEmpty;
  assign syncIdx   = syncBits(cfgSyncSel) - 7'd1 - strb.bitIdx;

  always_comb begin
    case (strb.field)
      FLD_PRE, FLD_TRAIL: curBit = ~strb.bitIdx[0];
      FLD_SYNC:           curBit = cfgSyncWord[syncIdx[5:0]];
      FLD_PAY:            curBit = strb.byteFirst ? headByte[7] : shReg[7];
      FLD_CRC:            curBit = crcReg[4'd15 - strb.bitIdx[3:0]];
      default:            curBit = 1'b0;
    endcase
  end

  assign crcNext = {crcReg[14:0], 1'b0} ^ ((crcReg[15] ^ curBit) ? 16'h1021 : 16'h0000);

  always_ff @(posedge clk) begin
    if (!clrBuf && wrEn && !fifoFull) mem[wrPtr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (clrBuf)                wrPtr <= '0;
      else if (wrEn && !fifoFull) wrPtr <= wrPtr + PW'(1);
      if (clrBuf || strb.rdRst)  rdPtr <= '0;
      else if (pop)              rdPtr <= rdPtr + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      crcReg    <= 16'hFFFF;
      underflow <= 1'b0;
      txBit     <= 1'b0;
      txStrobe  <= 1'b0;
      pktDone   <= 1'b0;
    end else begin
      txStrobe <= strb.emit;
      pktDone  <= strb.lastBit;
      if (strb.emit) txBit <= curBit;
      if (strb.crcInit) begin
        crcReg    <= 16'hFFFF;
        underflow <= 1'b0;
      end else if (strb.emit && strb.field == FLD_PAY) begin
        crcReg <= crcNext;
        shReg  <= strb.byteFirst ? {headByte[6:0], 1'b0} : {shReg[6:0], 1'b0};
        if (strb.byteFirst && fifoEmpty) underflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_framer_tx.sv
module pkt_framer_tx
  import framer_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PAYW  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            symTick,
  input  logic            startPulse,
  input  logic [2:0]      cfgPreLen,
  input  logic [1:0]      cfgSyncSel,
  input  logic [63:0]     cfgSyncWord,
  input  logic [4:0]      cfgTrailLen,
  input  logic            cfgCrcEn,
  input  logic [PAYW-1:0] cfgPayLen,
  input  logic            wrEn,
  input  logic [7:0]      wrData,
  input  logic            clrBuf,
  output logic            txBit,
  output logic            txStrobe,
  output logic            pktBusy,
  output logic            pktDone,
  output logic            underflow,
  output logic            fifoEmpty,
  output logic            fifoFull
);

  ctrlStrobeT strb;

  framer_ctrl #(.PAYW(PAYW)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .symTick(symTick),
    .cfgPreLen(cfgPreLen), .cfgSyncSel(cfgSyncSel), .cfgTrailLen(cfgTrailLen),
    .cfgCrcEn(cfgCrcEn), .cfgPayLen(cfgPayLen), .strb(strb), .busy(pktBusy)
  );

  framer_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSyncSel(cfgSyncSel),
    .cfgSyncWord(cfgSyncWord), .wrEn(wrEn), .wrData(wrData), .clrBuf(clrBuf),
    .txBit(txBit), .txStrobe(txStrobe), .pktDone(pktDone),
    .underflow(underflow), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

endmodule

// File: rtl/framer_chk.sv
module framer_chk (
  input logic clk,
  input logic rstN,
  input logic symTick,
  input logic startPulse,
  input logic wrEn,
  input logic clrBuf,
  input logic txStrobe,
  input logic pktBusy,
  input logic pktDone,
  input logic underflow,
  input logic fifoEmpty,
  input logic fifoFull
);

  // R7
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));

  // R7
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrEn && !clrBuf && !pktBusy) |=> fifoFull);

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrBuf |=> fifoEmpty);

  // R2
  strobe_from_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> $past(symTick && pktBusy));

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (txStrobe && $fell(pktBusy)));

  // R10
  strobe_idle_only_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txStrobe && !pktBusy) |-> pktDone);

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !startPulse) |=> underflow);

endmodule

bind pkt_framer_tx framer_chk chk_i (
  .clk(clk), .rstN(rstN), .symTick(symTick), .startPulse(startPulse),
  .wrEn(wrEn), .clrBuf(clrBuf), .txStrobe(txStrobe), .pktBusy(pktBusy),
  .pktDone(pktDone), .underflow(underflow), .fifoEmpty(fifoEmpty),
  .fifoFull(fifoFull)
);

// File: tb/pkt_framer_tx_tb_top.sv
module pkt_framer_tx_tb_top;

  typedef struct packed {
    logic [2:0] kind;   // 0 pre,1 sync,2 trail,3 fetch,4 paybit,5 crcbit
    logic       rst;
    logic       last;
    logic [7:0] val;
  } entT;

  logic clk = 1'b0, rstN = 1'b0, symTick = 1'b0, startPulse = 1'b0;
  logic [2:0] cfgPreLen = '0;
  logic [1:0] cfgSyncSel = '0;
  logic [63:0] cfgSyncWord = 64'h0123_4567_89AB_CDEF;
  logic [4:0] cfgTrailLen = 5'd4;
  logic cfgCrcEn = 1'b0;
  logic [7:0] cfgPayLen = '0;
  logic wrEn = 1'b0, clrBuf = 1'b0;
  logic [7:0] wrData = '0;
  logic txBit, txStrobe, pktBusy, pktDone, underflow, fifoEmpty, fifoFull;

  int errors = 0, checks = 0, cyc = 0, tickDiv = 0;

  pkt_framer_tx dut_i (
    .clk(clk), .rstN(rstN), .symTick(symTick), .startPulse(startPulse),
    .cfgPreLen(cfgPreLen), .cfgSyncSel(cfgSyncSel), .cfgSyncWord(cfgSyncWord),
    .cfgTrailLen(cfgTrailLen), .cfgCrcEn(cfgCrcEn), .cfgPayLen(cfgPayLen),
    .wrEn(wrEn), .wrData(wrData), .clrBuf(clrBuf), .txBit(txBit),
    .txStrobe(txStrobe), .pktBusy(pktBusy), .pktDone(pktDone),
    .underflow(underflow), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 3;
    symTick <= (tickDiv == 0);
  end

  // ---------------- reference model ----------------
  logic [7:0]  mMem [64];
  int          mWr = 0, mRd = 0, mLen = 0, nStrobe = 0;
  bit          mBusy = 0, mStrobe = 0, mBit = 0, mDone = 0, mUnder = 0;
  bit          mEmptyNow, mFullNow;
  logic [2:0]  mKind = 0;
  logic [15:0] mCrc = 16'hFFFF;
  logic [7:0]  mCur = 0;
  entT         q[$];
  entT         e;

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic entT mk(input logic [2:0] k, input logic [7:0] v);
    entT t;
    t.kind = k; t.rst = 1'b0; t.last = 1'b0; t.val = v;
    return t;
  endfunction

  task automatic buildPacket();
    int sw, tl;
    q.delete();
    for (int i = 0; i < (cfgPreLen + 1) * 8; i++) q.push_back(mk(3'd0, 8'((i % 2) == 0)));
    sw = (cfgSyncSel == 2'd0) ? 32 : (cfgSyncSel == 2'd1) ? 48 : 64;
    for (int i = sw - 1; i >= 0; i--) q.push_back(mk(3'd1, 8'(cfgSyncWord[i])));
    q[q.size()-1].rst = 1'b1;
    tl = (cfgTrailLen < 4) ? 4 : (cfgTrailLen > 16) ? 16 : int'(cfgTrailLen);
    for (int i = 0; i < tl; i++) q.push_back(mk(3'd2, 8'((i % 2) == 0)));
    for (int j = 0; j < cfgPayLen; j++) begin
      q.push_back(mk(3'd3, 8'd7));
      for (int k = 6; k >= 0; k--) q.push_back(mk(3'd4, 8'(k)));
    end
    if (cfgCrcEn) for (int k = 15; k >= 0; k--) q.push_back(mk(3'd5, 8'(k)));
    q[q.size()-1].last = 1'b1;
    mLen = q.size();
    mCrc = 16'hFFFF;
    mUnder = 0;
    mBusy = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mWr = 0; mRd = 0; mBusy = 0; mStrobe = 0; mDone = 0; mUnder = 0;
    end else begin
      mEmptyNow = (mWr == mRd);
      mFullNow  = (((mWr - mRd) & 127) == 64);
      mStrobe = 0;
      mDone = 0;
      if (mBusy) begin
        if (symTick) begin
          e = q.pop_front();
          mStrobe = 1;
          mKind = e.kind;
          case (e.kind)
            3'd3: begin
              if (mEmptyNow) begin mCur = 8'h00; mUnder = 1; end
              else begin mCur = mMem[mRd % 64]; mRd = (mRd + 1) % 128; end
              mCrc = crcByte(mCrc, mCur);
              mBit = mCur[7];
            end
            3'd4: mBit = mCur[e.val[2:0]];
            3'd5: mBit = mCrc[e.val[3:0]];
            default: mBit = e.val[0];
          endcase
          if (e.rst) mRd = 0;
          if (e.last) begin mBusy = 0; mDone = 1; end
        end
      end else if (startPulse) begin
        buildPacket();
      end
      if (clrBuf) begin
        mWr = 0; mRd = 0;
      end else if (wrEn && !mFullNow) begin
        mMem[mWr % 64] = wrData;
        mWr = (mWr + 1) % 128;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string tagOf(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd5: return "R6";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      chk("R10", "txStrobe", 16'(txStrobe), 16'(mStrobe));
      if (mStrobe) begin
        nStrobe++;
        chk(tagOf(mKind), "txBit", 16'(txBit), 16'(mBit));
      end
      chk("R10", "pktBusy", 16'(pktBusy), 16'(mBusy));
      chk("R10", "pktDone", 16'(pktDone), 16'(mDone));
      chk("R9", "underflow", 16'(underflow), 16'(mUnder));
      chk("R7", "fifoEmpty", 16'(fifoEmpty), 16'(mWr == mRd));
      chk("R7", "fifoFull", 16'(fifoFull), 16'(((mWr - mRd) & 127) == 64));
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wrByte(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearBuf();
    clrBuf = 1'b1;
    @(negedge clk);
    clrBuf = 1'b0;
  endtask

  task automatic loadBytes(input int n, input logic [7:0] seed);
    clearBuf();
    for (int i = 0; i < n; i++) wrByte(8'(seed + 8'(i * 37)));
  endtask

  task automatic startPkt();
    nStrobe = 0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    while (pktBusy) @(negedge clk);
    @(negedge clk);
    chk(tag, "bit count", 16'(nStrobe), 16'(mLen));
  endtask

  task automatic cfg(input logic [2:0] p, input logic [1:0] s, input logic [4:0] t,
                     input logic c, input logic [7:0] n);
    cfgPreLen = p; cfgSyncSel = s; cfgTrailLen = t; cfgCrcEn = c; cfgPayLen = n;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "txStrobe", 16'(txStrobe), 16'h0);
    chk("R1", "pktBusy", 16'(pktBusy), 16'h0);
    chk("R1", "pktDone", 16'(pktDone), 16'h0);
    chk("R1", "underflow", 16'(underflow), 16'h0);
    chk("R1", "fifoEmpty", 16'(fifoEmpty), 16'h1);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6: short packet, 32-bit sync, crc on
    loadBytes(4, 8'h5A);
    cfg(3'd0, 2'd0, 5'd4, 1'b1, 8'd4);
    startPkt();
    waitDone("R6");

    // R2 R3 R4: long preamble, 48-bit sync, 13-bit trailer, crc off
    cfgSyncWord = 64'hF0E1_D2C3_B4A5_9687;
    loadBytes(3, 8'hC3);
    cfg(3'd7, 2'd1, 5'd13, 1'b0, 8'd3);
    startPkt();
    waitDone("R3");

    // R4 clamp low, 64-bit sync via select 3
    loadBytes(2, 8'h11);
    cfg(3'd2, 2'd3, 5'd1, 1'b1, 8'd2);
    startPkt();
    waitDone("R4");

    // R4 clamp high, 64-bit sync via select 2
    loadBytes(5, 8'h80);
    cfg(3'd1, 2'd2, 5'd31, 1'b1, 8'd5);
    startPkt();
    waitDone("R4");

    // R9 underflow: 2 bytes available, 5 requested
    loadBytes(2, 8'hE7);
    cfg(3'd0, 2'd0, 5'd6, 1'b1, 8'd5);
    startPkt();
    waitDone("R9");
    chk("R9", "underflow held after packet", 16'(underflow), 16'h1);
    repeat (4) @(negedge clk);
    chk("R9", "underflow still held", 16'(underflow), 16'h1);

    // R12 zero payload with crc, start clears underflow (R9)
    clearBuf();
    cfg(3'd0, 2'd0, 5'd8, 1'b1, 8'd0);
    startPkt();
    chk("R9", "underflow cleared by start", 16'(underflow), 16'h0);
    waitDone("R12");

    // R12 zero payload without crc
    cfg(3'd1, 2'd0, 5'd5, 1'b0, 8'd0);
    startPkt();
    waitDone("R12");

    // R8 clear wins over a same-cycle write
    wrByte(8'h33);
    clrBuf = 1'b1; wrEn = 1'b1; wrData = 8'h44;
    @(negedge clk);
    clrBuf = 1'b0; wrEn = 1'b0;
    chk("R8", "fifoEmpty after clear+write", 16'(fifoEmpty), 16'h1);

    // R7 fill, overfill; R11 refill during an 80-byte packet; R10 start while busy
    loadBytes(64, 8'h21);
    chk("R7", "fifoFull after 64 writes", 16'(fifoFull), 16'h1);
    wrByte(8'hFF);
    chk("R7", "still full after dropped write", 16'(fifoFull), 16'h1);
    cfg(3'd1, 2'd1, 5'd8, 1'b1, 8'd80);
    startPkt();
    repeat (40) @(negedge clk);
    startPkt();
    nStrobe = 0;
    while (!fifoEmpty && fifoFull) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      while (fifoFull) @(negedge clk);
      wrByte(8'(8'h90 + 8'(i)));
    end
    while (pktBusy) @(negedge clk);
    @(negedge clk);
    chk("R11", "no underflow with refill", 16'(underflow), 16'h0);
    chk("R10", "idle after packet despite second start", 16'(pktBusy), 16'h0);

    // R5 read position returns to slot 0 at sync end
    loadBytes(3, 8'h0F);
    cfg(3'd0, 2'd0, 5'd4, 1'b1, 8'd3);
    startPkt();
    waitDone("R5");

    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule